// File: doc/BRIEF.md
# Parallel RC4 Key-Search Engine

The engine searches a 24-bit RC4 key space by brute force. A parameterised number of identical cores each step through their own interleaved share of the keys. For every candidate, a core runs the RC4 key schedule on a private 256-byte state, then generates keystream over a length-prefixed ciphertext. Each byte it decrypts must be printable. A core drops its current key at the first byte that fails and moves on to its next key.

A start pulse tells the engine to copy the 256-byte ciphertext buffer through a synchronous read port into a shared internal copy, and then to release all cores at once. The first core to finish a key whose whole plaintext passes wins. The engine then re-decrypts with that key and streams the length-prefixed plaintext out through a write port. After that it raises done with found high and holds the key. If every core runs out of keys, done rises with found low. A new start pulse restarts the engine from any state without a reset.

Top module: `rc4_search_top`

## Requirements
- R1: Decryption is standard RC4. The key schedule runs over a 256-entry, 8-bit state. The three key bytes are used in big-endian order: byte 0 is `key[23:16]`, and step i of the schedule uses key byte i mod 3. Keystream generation follows the schedule with i = j = 0.
- R2: The ciphertext port is read at addresses 0 to 255 in order, and the data arrives on `ct_data_i` one cycle after its address. Byte 0 is the message length L, and bytes 1 to L hold the data.
- R3: A key passes only if every plaintext byte 1..L lies in 0x20..0x7E inclusive. The values 0x1F and 0x7F fail.
- R4: Core c (0 ≤ c < NUM_CORES) tests keys c, c+NUM_CORES, c+2·NUM_CORES, and so on. It tests only keys below KEY_SPACE.
- R5: Cost of one key: a key that fails at byte p costs 257+p cycles, and a passing key completes 257+L cycles after it starts. All cores start together. The winner is the core whose passing key completes earliest, and if several complete in the same cycle the lowest-indexed core wins.
- R6: Before done rises, the engine writes the winning plaintext to the write port. Address 0 receives L, and address k receives plaintext byte k for k = 1..L. The data bytes are written on consecutive cycles with rising addresses.
- R7: `found_o` is only ever high together with `done_o`. `done_o`, `found_o` and `key_o` hold their values until the next start.
- R8: If no key below KEY_SPACE passes, `done_o` rises with `found_o` low and no plaintext write happens.
- R9: If L = 0, every key passes, all cores complete in the same cycle, and the engine reports key 0 and writes only address 0.
- R10: A start pulse restarts the engine from any state, including mid-search. `done_o` is low in the cycle after the pulse.
- R11: After reset, `done_o`, `found_o`, `pt_we_o` and `ct_re_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous pulse that starts or restarts a search |
| ct_re_o | output | 1 | Ciphertext read enable |
| ct_addr_o | output | 8 | Ciphertext read address |
| ct_data_i | input | 8 | Ciphertext data, one cycle after its address |
| done_o | output | 1 | Search finished |
| found_o | output | 1 | A key was found (valid while done is high) |
| key_o | output | 24 | Winning key, big-endian |
| pt_we_o | output | 1 | Plaintext write enable |
| pt_addr_o | output | 8 | Plaintext write address |
| pt_data_o | output | 8 | Plaintext write data |

## Verification
The bench builds the engine with NUM_CORES = 4 and KEY_SPACE = 64, so each core owns 16 keys. At that size a full exhaustion of the space fits in a few thousand cycles, and the bench can drive the not-found outcome. The bench model works out, for each core, how many cycles its attempts cost and where each key fails. From that it predicts the winner by completion time and core index, not by key order, including the all-cores tie that a zero-length message produces. Further cases cover a restart in the middle of a search and a message whose plaintext sits exactly on the 0x20 and 0x7E edges.

// File: rtl/rc4_search_pkg.sv
package rc4_search_pkg;
  localparam int STATE_N = 256;
  localparam int KEY_W   = 24;

  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    C_IDLE, C_INIT, C_KSA, C_PRGA, C_PASS, C_EXH
  } core_st_e;

  typedef enum logic [2:0] {
    T_IDLE, T_LOAD, T_SEARCH, T_EMIT_REQ, T_EMIT_WAIT, T_DONE
  } top_st_e;

  function automatic logic is_printable(byte_t b);
    return (b >= 8'h20) && (b <= 8'h7e);
  endfunction
endpackage

// File: rtl/rc4_ct_buffer.sv
module rc4_ct_buffer import rc4_search_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_start_i,
  output logic  load_done_o,
  output logic  ct_re_o,
  output logic [7:0] ct_addr_o,
  input  byte_t ct_data_i,
  output byte_t mem_o [STATE_N]
);
  logic [8:0] cnt_q;
  logic       busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 9'd1;
      if (cnt_q == 9'd256) busy_q <= 1'b0;
    end
  end

  // data returns one cycle after its address
  always_ff @(posedge clk_i) begin
    if (busy_q && !load_start_i && cnt_q != 9'd0)
      mem_o[8'(cnt_q - 9'd1)] <= ct_data_i;
  end

  assign ct_re_o     = busy_q && (cnt_q < 9'd256);
  assign ct_addr_o   = cnt_q[7:0];
  assign load_done_o = busy_q && (cnt_q == 9'd256);
endmodule

// File: rtl/rc4_key_core.sv
module rc4_key_core import rc4_search_pkg::*; #(
  parameter int CORE_IDX  = 0,
  parameter int NUM_CORES = 4,
  parameter int KEY_SPACE = 1 << 24
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  restart_i,
  input  logic  replay_i,
  input  logic  run_i,
  input  byte_t ct_i [STATE_N],
  output logic  pass_o,
  output logic  exh_o,
  output logic [KEY_W-1:0] key_o,
  output logic  emit_we_o,
  output byte_t emit_addr_o,
  output byte_t emit_data_o
);
  localparam logic [KEY_W:0] SPACE_L = (KEY_W+1)'(KEY_SPACE);
  localparam logic [KEY_W:0] STEP_L  = (KEY_W+1)'(NUM_CORES);
  localparam logic [KEY_W:0] FIRST_L = (KEY_W+1)'(CORE_IDX);

  core_st_e st_q;
  logic [KEY_W:0] cand_q;
  byte_t s_q [STATE_N];
  byte_t i_q, j_q, k_q;
  logic [1:0] kb_q;
  logic emit_q;

  byte_t key_byte, j_ksa, i_nx, s_i, j_nx, s_j, t_idx, ks, pt_byte;
  logic  adv, hold;

  assign adv  = run_i | emit_q;
  assign hold = restart_i | replay_i;

  always_comb begin
    unique case (kb_q)
      2'd0:    key_byte = cand_q[23:16];
      2'd1:    key_byte = cand_q[15:8];
      default: key_byte = cand_q[7:0];
    endcase
    j_ksa = j_q + s_q[i_q] + key_byte;
    i_nx  = i_q + 8'd1;
    s_i   = s_q[i_nx];
    j_nx  = j_q + s_i;
    s_j   = s_q[j_nx];
    t_idx = s_i + s_j;
    // keystream byte read from the post-swap state
    if (t_idx == i_nx)      ks = s_j;
    else if (t_idx == j_nx) ks = s_i;
    else                    ks = s_q[t_idx];
    pt_byte = ct_i[k_q] ^ ks;
  end

  always_ff @(posedge clk_i) begin
    if (!hold && adv) begin
      unique case (st_q)
        C_INIT: for (int n = 0; n < STATE_N; n++) s_q[n] <= 8'(n);
        C_KSA: begin
          s_q[i_q]   <= s_q[j_ksa];
          s_q[j_ksa] <= s_q[i_q];
        end
        C_PRGA: begin
          s_q[i_nx] <= s_j;
          s_q[j_nx] <= s_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= C_IDLE;
      cand_q <= FIRST_L;
      i_q    <= '0;
      j_q    <= '0;
      k_q    <= '0;
      kb_q   <= '0;
      emit_q <= 1'b0;
    end else if (restart_i) begin
      cand_q <= FIRST_L;
      emit_q <= 1'b0;
      st_q   <= (FIRST_L < SPACE_L) ? C_INIT : C_EXH;
    end else if (replay_i) begin
      emit_q <= 1'b1;
      st_q   <= C_INIT;
    end else if (adv) begin
      unique case (st_q)
        C_INIT: begin
          i_q  <= '0;
          j_q  <= '0;
          kb_q <= '0;
          st_q <= C_KSA;
        end
        C_KSA: begin
          i_q  <= i_q + 8'd1;
          j_q  <= j_ksa;
          kb_q <= (kb_q == 2'd2) ? 2'd0 : kb_q + 2'd1;
          if (i_q == 8'hff) begin
            j_q <= '0;
            k_q <= 8'd1;
            if (ct_i[0] == 8'd0) begin
              st_q   <= C_PASS;
              emit_q <= 1'b0;
            end else begin
              st_q <= C_PRGA;
            end
          end
        end
        C_PRGA: begin
          i_q <= i_nx;
          j_q <= j_nx;
          k_q <= k_q + 8'd1;
          if (!emit_q && !is_printable(pt_byte)) begin
            if (cand_q + STEP_L >= SPACE_L) begin
              st_q <= C_EXH;
            end else begin
              cand_q <= cand_q + STEP_L;
              st_q   <= C_INIT;
            end
          end else if (k_q == ct_i[0]) begin
            st_q   <= C_PASS;
            emit_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign pass_o      = (st_q == C_PASS);
  assign exh_o       = (st_q == C_EXH);
  assign key_o       = cand_q[KEY_W-1:0];
  assign emit_we_o   = emit_q && (st_q == C_PRGA);
  assign emit_addr_o = k_q;
  assign emit_data_o = pt_byte;
endmodule

// File: rtl/rc4_winner_pick.sv
module rc4_winner_pick #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_CORES-1:0] pass_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    any_o = |pass_i;
    idx_o = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (pass_i[c]) idx_o = IDX_W'(c);
    end
  end
endmodule

// File: rtl/rc4_search_top.sv
module rc4_search_top import rc4_search_pkg::*; #(
  parameter int NUM_CORES = 4,
  parameter int KEY_SPACE = 1 << 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              ct_re_o,
  output logic [7:0]        ct_addr_o,
  input  logic [7:0]        ct_data_i,
  output logic              done_o,
  output logic              found_o,
  output logic [KEY_W-1:0]  key_o,
  output logic              pt_we_o,
  output logic [7:0]        pt_addr_o,
  output logic [7:0]        pt_data_o
);
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  top_st_e st_q;
  logic [IDX_W-1:0] win_q, pick_idx;
  logic             pick_any, load_done;
  logic             done_q, found_q;
  logic [KEY_W-1:0] key_q;
  byte_t            ct_mem [STATE_N];

  logic [NUM_CORES-1:0] c_pass, c_exh, c_emit_we, c_replay;
  logic [KEY_W-1:0]     c_key  [NUM_CORES];
  byte_t                c_addr [NUM_CORES];
  byte_t                c_data [NUM_CORES];
  logic                 core_restart, core_run;

  rc4_ct_buffer u_ctbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_start_i (start_i),
    .load_done_o  (load_done),
    .ct_re_o      (ct_re_o),
    .ct_addr_o    (ct_addr_o),
    .ct_data_i    (ct_data_i),
    .mem_o        (ct_mem)
  );

  assign core_restart = start_i | ((st_q == T_LOAD) && load_done);
  assign core_run     = (st_q == T_SEARCH);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign c_replay[c] = (st_q == T_EMIT_REQ) && (win_q == IDX_W'(c));
    rc4_key_core #(
      .CORE_IDX  (c),
      .NUM_CORES (NUM_CORES),
      .KEY_SPACE (KEY_SPACE)
    ) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .restart_i   (core_restart),
      .replay_i    (c_replay[c]),
      .run_i       (core_run),
      .ct_i        (ct_mem),
      .pass_o      (c_pass[c]),
      .exh_o       (c_exh[c]),
      .key_o       (c_key[c]),
      .emit_we_o   (c_emit_we[c]),
      .emit_addr_o (c_addr[c]),
      .emit_data_o (c_data[c])
    );
  end

  rc4_winner_pick #(.NUM_CORES(NUM_CORES)) u_pick (
    .pass_i (c_pass),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= T_IDLE;
      win_q   <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      key_q   <= '0;
    end else if (start_i) begin
      st_q    <= T_LOAD;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      key_q   <= '0;
    end else begin
      unique case (st_q)
        T_LOAD: if (load_done) st_q <= T_SEARCH;
        T_SEARCH: begin
          if (pick_any) begin
            win_q <= pick_idx;
            st_q  <= T_EMIT_REQ;
          end else if (&c_exh) begin
            st_q   <= T_DONE;
            done_q <= 1'b1;
          end
        end
        T_EMIT_REQ: st_q <= T_EMIT_WAIT;
        T_EMIT_WAIT: begin
          if (c_pass[win_q]) begin
            st_q    <= T_DONE;
            done_q  <= 1'b1;
            found_q <= 1'b1;
            key_q   <= c_key[win_q];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (st_q == T_EMIT_REQ) begin
      pt_we_o   = 1'b1;
      pt_addr_o = 8'd0;
      pt_data_o = ct_mem[0];
    end else begin
      pt_we_o   = (st_q == T_EMIT_WAIT) && c_emit_we[win_q];
      pt_addr_o = c_addr[win_q];
      pt_data_o = c_data[win_q];
    end
  end

  assign done_o  = done_q;
  assign found_o = found_q;
  assign key_o   = key_q;
endmodule

// File: rtl/rc4_search_chk.sv
module rc4_search_chk #(
  parameter int KEY_SPACE = 1 << 24
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        ct_re_o,
  input logic        done_o,
  input logic        found_o,
  input logic [23:0] key_o,
  input logic        pt_we_o,
  input logic [7:0]  pt_addr_o
);
  assert_found_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> done_o);

  assert_done_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(found_o) && $stable(key_o)));

  assert_start_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !found_o));

  assert_write_before_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_we_o |-> !done_o);

  assert_consecutive_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_we_o && $past(pt_we_o)) |-> (pt_addr_o == $past(pt_addr_o) + 8'd1));

  assert_key_in_space_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> ({1'b0, key_o} < 25'(KEY_SPACE)));

  assert_no_read_when_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ct_re_o |-> !done_o);
endmodule

bind rc4_search_top rc4_search_chk #(.KEY_SPACE(KEY_SPACE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ct_re_o   (ct_re_o),
  .done_o    (done_o),
  .found_o   (found_o),
  .key_o     (key_o),
  .pt_we_o   (pt_we_o),
  .pt_addr_o (pt_addr_o)
);

// File: tb/sim_rc4_search_top.sv
module sim_rc4_search_top;
  localparam int NC = 4;
  localparam int KS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ct_re, done, found, pt_we;
  logic [7:0] ct_addr, ct_data, pt_addr, pt_data;
  logic [23:0] key;

  logic [7:0] ct_mem [256];
  logic [7:0] got_pt [256];
  logic [7:0] exp_pt [256];
  int wr_cnt;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rc4_search_top #(.NUM_CORES(NC), .KEY_SPACE(KS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ct_re_o(ct_re), .ct_addr_o(ct_addr), .ct_data_i(ct_data),
    .done_o(done), .found_o(found), .key_o(key),
    .pt_we_o(pt_we), .pt_addr_o(pt_addr), .pt_data_o(pt_data)
  );

  always @(posedge clk) ct_data <= ct_mem[ct_addr];

  always @(negedge clk) begin
    if (pt_we) begin
      got_pt[pt_addr] = pt_data;
      wr_cnt++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // keystream bytes 1..255 for a key
  task automatic rc4_ks(input int k, output logic [7:0] ks [256]);
    int s [256];
    int kb [3];
    int j, i, tmp;
    kb[0] = (k >> 16) & 255; kb[1] = (k >> 8) & 255; kb[2] = k & 255;
    for (int n = 0; n < 256; n++) s[n] = n;
    j = 0;
    for (int n = 0; n < 256; n++) begin
      j = (j + s[n] + kb[n % 3]) & 255;
      tmp = s[n]; s[n] = s[j]; s[j] = tmp;
    end
    i = 0; j = 0; ks[0] = 8'h00;
    for (int n = 1; n < 256; n++) begin
      i = (i + 1) & 255;
      j = (j + s[i]) & 255;
      tmp = s[i]; s[i] = s[j]; s[j] = tmp;
      ks[n] = 8'(s[(s[i] + s[j]) & 255]);
    end
  endtask

  task automatic make_ct(input int k, input string msg);
    logic [7:0] ks [256];
    rc4_ks(k, ks);
    for (int n = 0; n < 256; n++) ct_mem[n] = 8'h00;
    ct_mem[0] = 8'(msg.len());
    for (int n = 1; n <= msg.len(); n++) ct_mem[n] = msg[n-1] ^ ks[n];
  endtask

  // first failing byte position, 0 if all pass
  task automatic eval_key(input int k, output int fail_at);
    logic [7:0] ks [256];
    logic [7:0] b;
    rc4_ks(k, ks);
    fail_at = 0;
    for (int n = 1; n <= int'(ct_mem[0]); n++) begin
      b = ct_mem[n] ^ ks[n];
      if (fail_at == 0 && (b < 8'h20 || b > 8'h7e)) fail_at = n;
    end
  endtask

  task automatic model(output bit ef, output int ek);
    longint best;
    int len, p;
    logic [7:0] ks [256];
    best = 64'h7fffffffffffffff; ef = 1'b0; ek = 0;
    len = int'(ct_mem[0]);
    for (int c = 0; c < NC; c++) begin
      longint t;
      t = 0;
      for (int k = c; k < KS; k += NC) begin
        eval_key(k, p);
        if (p == 0) begin
          if (t + 257 + len < best) begin
            best = t + 257 + len; ef = 1'b1; ek = k;
          end
          break;
        end
        t += 257 + p;
      end
    end
    exp_pt[0] = ct_mem[0];
    if (ef) begin
      rc4_ks(ek, ks);
      for (int n = 1; n <= len; n++) exp_pt[n] = ct_mem[n] ^ ks[n];
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_case(input string req);
    bit ef;
    int ek, cyc, len;
    model(ef, ek);
    len = int'(ct_mem[0]);
    for (int n = 0; n < 256; n++) got_pt[n] = 8'h00;
    wr_cnt = 0;
    pulse_start();
    chk("R10", "done low after start", 32'(done), 32'd0);
    cyc = 0;
    while (!done && cyc < 30000) begin
      @(negedge clk); cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL %s watchdog: actual busy expected done", req);
    end
    chk(req, "found", 32'(found), 32'(ef));
    if (ef) begin
      chk(req, "key", 32'(key), 32'(ek));
      chk("R6", "write count", 32'(wr_cnt), 32'(len + 1));
      for (int n = 0; n <= len; n++) chk("R6", "plaintext byte", 32'(got_pt[n]), 32'(exp_pt[n]));
    end else begin
      chk("R8", "no writes", 32'(wr_cnt), 32'd0);
    end
    repeat (3) @(negedge clk);
    chk("R7", "done held", 32'(done), 32'd1);
    chk("R7", "found held", 32'(found), 32'(ef));
  endtask

  initial begin
    for (int n = 0; n < 256; n++) ct_mem[n] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R11", "done", 32'(done), 32'd0);
    chk("R11", "found", 32'(found), 32'd0);
    chk("R11", "pt_we", 32'(pt_we), 32'd0);
    chk("R11", "ct_re", 32'(ct_re), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: empty message, all cores tie, core 0 wins with key 0
    make_ct(0, "");
    run_case("R9");
    chk("R9", "key zero", 32'(key), 32'd0);

    // R1 R4 R5: ordinary message
    make_ct(45, "Hi there!");
    run_case("R1");

    // R3: plaintext on the printable edges
    make_ct(22, " ~ ~~  ~");
    run_case("R3");

    // R10: restart mid-search with a new message
    make_ct(3, "restart check");
    pulse_start();
    repeat (600) @(negedge clk);
    chk("R10", "busy mid-search", 32'(done), 32'd0);
    make_ct(58, "second run ok");
    run_case("R5");

    // R8: key outside the space, nothing passes
    make_ct(24'h5a5a5a, "no such key in range!");
    run_case("R8");

    // R2 R4: another message after a failed run
    make_ct(7, "Key seven");
    run_case("R4");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule